// File: doc/BRIEF.md
# Multi-Mode 16-bit Period Timer

This block is a count register that moves only on cycles where a timer clock enable is high. A two-bit mode input picks what it does on each enabled cycle. It can hold still. It can climb to a programmable period and start again from zero. It can run freely through the full count range. It can also climb to the period and descend back to zero, over and over. The period is held in a register that software loads through a one-cycle write strobe. A write may land while the counter is running.

Two sticky flags mark timing events. One flag records that the count arrived at the period value. The other records a wrap back to zero. Each flag has its own clear strobe and its own enable. A single interrupt request line is raised while any enabled flag is set. In up/down mode, the direction of travel is a two-state machine with the states `DIR_UP` and `DIR_DOWN`. Its transitions are as follows:
- *turn-down*: `DIR_UP`→`DIR_DOWN` when the count is at or above the period.
- *turn-up*: `DIR_DOWN`→`DIR_UP` when the count lands on zero.
- *realign*: any enabled tick in up or free-running mode forces `DIR_UP`.

Stop mode leaves the direction untouched, so an up/down run that is paused picks up where it left off.

Top module: `mode_timer16`

## Requirements
- R1: While reset is asserted (rst_n low), the count is 0, the direction is up, the period register is 0, both flags are 0 and irq is 0.
- R2: The count changes only on clock cycles with tick_en high. Mode encoding: 00 = stop, 01 = up, 10 = free-running, 11 = up/down. In stop mode (00) the count holds its value even when tick_en is high.
- R3: In free-running mode (10), each tick adds 1. From 0xFFFF the count goes to 0, and that tick sets the wrap flag. The period-match flag is set on the tick where the count arrives at the period value.
- R4: In up mode (01), the count goes 0,1,…,P and then 0 on the next tick, so one cycle takes P+1 ticks (P is the period register).
- R5: In up mode, the period-match flag is set on the tick where the count reaches P. The wrap flag is set on the tick where the count goes from P to 0, and on no earlier tick.
- R6: In up/down mode (11), the count climbs from 0 to P and then falls back to 0, repeating. With P=3 the sequence after reset is 1,2,3,2,1,0,1.
- R7: In up/down mode, the period-match flag is set on the tick that brings the count up to P. The wrap flag is set on the tick where the descending count reaches 0, and the next tick counts upward.
- R8: If up mode is entered while the count is above P, the next tick sets the count to 0 without setting the wrap flag.
- R9: A period write (period_wr high) loads period_wdata at that clock edge whether or not tick_en is high. In up mode, a new period at or above the count lets counting continue up to it. A new period below the count sends the count to 0 on the next tick.
- R10: With P=0 in up mode, the count stays 0 and every tick sets both flags.
- R11: Flags stay set until their clear strobe (clr_match, clr_wrap) is high for a cycle. If a set and a clear fall on the same cycle, the flag ends up set.
- R12: irq is high exactly when (match_flag and match_ie) or (wrap_flag and wrap_ie) holds, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timer clock enable; the count advances only when high |
| mode | input | 2 | Counting mode: 00 stop, 01 up, 10 free-running, 11 up/down |
| period_wr | input | 1 | Period register write strobe |
| period_wdata | input | 16 | Value loaded into the period register |
| clr_match | input | 1 | Clear strobe for the period-match flag |
| clr_wrap | input | 1 | Clear strobe for the wrap flag |
| match_ie | input | 1 | Lets the period-match flag drive irq |
| wrap_ie | input | 1 | Lets the wrap flag drive irq |
| count | output | 16 | Current count value |
| match_flag | output | 1 | Sticky period-match flag |
| wrap_flag | output | 1 | Sticky wrap flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the exact tick on which each flag is set. A design that is one tick early or late would show the wrap flag while the count still sits at P or 0xFFFF, or would miss it after the wrap.

It enters up mode with the count above the period, and it shrinks the period beneath a running count. A comparator that tests only for equality would then run on toward 0xFFFF instead of returning to zero.

The up/down run checks that the counter reverses at both ends. A broken direction machine would overshoot P or go below zero.

Finally, the bench checks that a set and a clear on the same cycle leave the flag set. It also checks that a zero period holds the count at zero while both flags are set on every tick.

// File: rtl/mt_pkg.sv
package mt_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_UPDN = 2'b11
    } mt_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } mt_dir_e;

    typedef struct packed {
        logic hit_period;
        logic wrap;
    } mt_evt_t;

    localparam int unsigned EVT_MATCH = 0;
    localparam int unsigned EVT_WRAP  = 1;
    localparam int unsigned NUM_EVT   = 2;

endpackage

// File: rtl/mt_period_reg.sv
module mt_period_reg #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] period
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period <= RST_VAL;
        end else if (wr) begin
            period <= wdata;
        end
    end

endmodule

// File: rtl/mt_count_fsm.sv
module mt_count_fsm
    import mt_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  mt_mode_e         mode,
    input  logic [WIDTH-1:0] period,
    output logic [WIDTH-1:0] count,
    output mt_evt_t          evt
);

    localparam logic [WIDTH-1:0] FULL_SCALE = '1;
    localparam logic [WIDTH-1:0] ONE        = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO       = '0;

    mt_dir_e          dir_q, dir_nx;
    logic [WIDTH-1:0] cnt_nx;
    logic             below_period;

    assign below_period = (count < period);

    // state register: count value and direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= ZERO;
            dir_q <= DIR_UP;
        end else begin
            count <= cnt_nx;
            dir_q <= dir_nx;
        end
    end

    // next-state and event outputs
    always_comb begin
        cnt_nx = count;
        dir_nx = dir_q;
        evt    = '0;
        if (tick_en) begin
            unique case (mode)
                MODE_STOP: begin
                    cnt_nx = count;
                end
                MODE_CONT: begin
                    dir_nx         = DIR_UP;
                    cnt_nx         = count + ONE;
                    evt.wrap       = (count == FULL_SCALE);
                    evt.hit_period = (cnt_nx == period);
                end
                MODE_UP: begin
                    dir_nx = DIR_UP;
                    if (below_period) begin
                        cnt_nx = count + ONE;
                    end else begin
                        cnt_nx = ZERO;
                    end
                    evt.wrap       = (count == period);
                    evt.hit_period = (cnt_nx == period);
                end
                MODE_UPDN: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (below_period) begin
                                cnt_nx         = count + ONE;
                                evt.hit_period = (cnt_nx == period);
                            end else if (count == ZERO) begin
                                cnt_nx   = ZERO;
                                evt.wrap = 1'b1;
                            end else begin
                                dir_nx = DIR_DOWN;
                                cnt_nx = count - ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (count <= ONE) begin
                                cnt_nx   = ZERO;
                                dir_nx   = DIR_UP;
                                evt.wrap = 1'b1;
                            end else begin
                                cnt_nx = count - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/mt_flag_cell.sv
module mt_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
        end
    end

    assign req = flag & en;

endmodule

// File: rtl/mode_timer16.sv
module mode_timer16
    import mt_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] PERIOD_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       mode,
    input  logic             period_wr,
    input  logic [WIDTH-1:0] period_wdata,
    input  logic             clr_match,
    input  logic             clr_wrap,
    input  logic             match_ie,
    input  logic             wrap_ie,
    output logic [WIDTH-1:0] count,
    output logic             match_flag,
    output logic             wrap_flag,
    output logic             irq
);

    mt_mode_e         mode_e;
    logic [WIDTH-1:0] period_q;
    mt_evt_t          evt;
    logic [NUM_EVT-1:0] set_v, clr_v, en_v, flag_v, req_v;

    assign mode_e = mt_mode_e'(mode);

    mt_period_reg #(.WIDTH(WIDTH), .RST_VAL(PERIOD_RST)) u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (period_wr),
        .wdata  (period_wdata),
        .period (period_q)
    );

    mt_count_fsm #(.WIDTH(WIDTH)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .mode    (mode_e),
        .period  (period_q),
        .count   (count),
        .evt     (evt)
    );

    assign set_v[EVT_MATCH] = evt.hit_period;
    assign set_v[EVT_WRAP]  = evt.wrap;
    assign clr_v[EVT_MATCH] = clr_match;
    assign clr_v[EVT_WRAP]  = clr_wrap;
    assign en_v[EVT_MATCH]  = match_ie;
    assign en_v[EVT_WRAP]   = wrap_ie;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
        mt_flag_cell u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_v[g]),
            .clr   (clr_v[g]),
            .en    (en_v[g]),
            .flag  (flag_v[g]),
            .req   (req_v[g])
        );
    end

    assign match_flag = flag_v[EVT_MATCH];
    assign wrap_flag  = flag_v[EVT_WRAP];
    assign irq        = |req_v;

endmodule

// File: rtl/mode_timer16_chk.sv
module mode_timer16_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [1:0]       mode,
    input logic             period_wr,
    input logic [WIDTH-1:0] period_q,
    input logic [WIDTH-1:0] count,
    input logic             clr_match,
    input logic             clr_wrap,
    input logic             match_flag,
    input logic             wrap_flag,
    input logic             irq
);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count));

    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mode == 2'b00) |=> $stable(count));

    // R3
    cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mode == 2'b10) |=> count == WIDTH'($past(count) + 1));

    // R3
    cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mode == 2'b10 && count == '1) |=> (wrap_flag && count == '0));

    // R4
    up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && mode == 2'b01 && !period_wr) |=> count <= period_q);

    // R11
    match_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !clr_match) |=> match_flag);

    // R11
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flag && !clr_wrap) |=> wrap_flag);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_flag && !wrap_flag) |-> !irq);

endmodule

bind mode_timer16 mode_timer16_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .mode       (mode),
    .period_wr  (period_wr),
    .period_q   (period_q),
    .count      (count),
    .clr_match  (clr_match),
    .clr_wrap   (clr_wrap),
    .match_flag (match_flag),
    .wrap_flag  (wrap_flag),
    .irq        (irq)
);

// File: tb/mode_timer16_test.sv
module mode_timer16_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        period_wr = 1'b0;
    logic [15:0] period_wdata = '0;
    logic        clr_match = 1'b0;
    logic        clr_wrap = 1'b0;
    logic        match_ie = 1'b0;
    logic        wrap_ie = 1'b0;
    logic [15:0] count;
    logic        match_flag, wrap_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mode_timer16 uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
        .period_wr(period_wr), .period_wdata(period_wdata),
        .clr_match(clr_match), .clr_wrap(clr_wrap),
        .match_ie(match_ie), .wrap_ie(wrap_ie),
        .count(count), .match_flag(match_flag), .wrap_flag(wrap_flag), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        tick_en = 1'b0; mode = 2'b00; period_wr = 1'b0;
        clr_match = 1'b0; clr_wrap = 1'b0; match_ie = 1'b0; wrap_ie = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic load_period(input logic [15:0] v);
        period_wr = 1'b1; period_wdata = v;
        step(1);
        period_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1);
        chk("R1 count", count, 0);
        chk("R1 match_flag", match_flag, 0);
        chk("R1 wrap_flag", wrap_flag, 0);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_stop();
        do_reset();
        mode = 2'b10; tick_en = 1'b1;
        step(3);
        chk("R2 run before stop", count, 3);
        mode = 2'b00;
        step(4);
        chk("R2 stop holds", count, 3);
        mode = 2'b10; tick_en = 1'b0;
        step(3);
        chk("R2 no tick holds", count, 3);
    endtask

    task automatic t_cont();
        do_reset();
        load_period(16'd5);
        mode = 2'b10; tick_en = 1'b1;
        step(4);
        chk("R3 count 4", count, 4);
        chk("R3 no match yet", match_flag, 0);
        step(1);
        chk("R3 match at period", match_flag, 1);
        step(16'hFFFF - 5);
        chk("R3 full scale", count, 16'hFFFF);
        chk("R3 no wrap at full", wrap_flag, 0);
        step(1);
        chk("R3 wrapped count", count, 0);
        chk("R3 wrap flag", wrap_flag, 1);
    endtask

    task automatic t_up();
        do_reset();
        load_period(16'd4);
        mode = 2'b01; tick_en = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            step(1);
            chk("R4 climb", count, i);
            chk("R5 match timing", match_flag, (i == 4) ? 1 : 0);
            chk("R5 no early wrap", wrap_flag, 0);
        end
        step(1);
        chk("R4 restart after P+1 ticks", count, 0);
        chk("R5 wrap on P to 0", wrap_flag, 1);
        clr_match = 1'b1;
        step(1);
        clr_match = 1'b0;
        chk("R11 clear match", match_flag, 0);
        chk("R11 wrap stays", wrap_flag, 1);
        step(2);
        chk("R11 count 3", count, 3);
        clr_match = 1'b1;
        step(1);
        clr_match = 1'b0;
        chk("R11 set wins over clear", match_flag, 1);
        tick_en = 1'b0;
        chk("R12 masked irq", irq, 0);
        match_ie = 1'b1;
        #1;
        chk("R12 match enabled irq", irq, 1);
        match_ie = 1'b0; wrap_ie = 1'b1;
        #1;
        chk("R12 wrap enabled irq", irq, 1);
        clr_wrap = 1'b1;
        step(1);
        clr_wrap = 1'b0;
        chk("R12 irq after wrap clear", irq, 0);
    endtask

    task automatic t_updn();
        int exp_seq [7] = '{1, 2, 3, 2, 1, 0, 1};
        do_reset();
        load_period(16'd3);
        mode = 2'b11; tick_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            step(1);
            chk("R6 up/down sequence", count, exp_seq[i]);
            if (i == 2) chk("R7 match at top", match_flag, 1);
            if (i == 1) chk("R7 no early match", match_flag, 0);
            if (i == 4) chk("R7 no early wrap", wrap_flag, 0);
            if (i == 5) chk("R7 wrap at bottom", wrap_flag, 1);
        end
    endtask

    task automatic t_enter_above();
        do_reset();
        load_period(16'd4);
        mode = 2'b10; tick_en = 1'b1;
        step(10);
        chk("R8 count above period", count, 10);
        mode = 2'b01;
        step(1);
        chk("R8 restart at zero", count, 0);
        chk("R8 no wrap flag", wrap_flag, 0);
    endtask

    task automatic t_rewrite();
        do_reset();
        load_period(16'd8);
        mode = 2'b01; tick_en = 1'b1;
        step(5);
        chk("R9 count 5", count, 5);
        tick_en = 1'b0;
        load_period(16'd6);
        chk("R9 write without tick", count, 5);
        tick_en = 1'b1;
        step(1);
        chk("R9 climbs to new period", count, 6);
        step(1);
        chk("R9 restart at new period", count, 0);
        chk("R9 wrap at new period", wrap_flag, 1);
        step(5);
        tick_en = 1'b0;
        load_period(16'd2);
        tick_en = 1'b1;
        step(1);
        chk("R9 shrink below count", count, 0);
    endtask

    task automatic t_zero_period();
        do_reset();
        load_period(16'd0);
        mode = 2'b01; tick_en = 1'b1;
        step(3);
        chk("R10 stays zero", count, 0);
        chk("R10 match set", match_flag, 1);
        chk("R10 wrap set", wrap_flag, 1);
        tick_en = 1'b0; clr_match = 1'b1; clr_wrap = 1'b1;
        step(1);
        clr_match = 1'b0; clr_wrap = 1'b0;
        chk("R10 cleared", {match_flag, wrap_flag}, 0);
        tick_en = 1'b1;
        step(1);
        chk("R10 both set again", {match_flag, wrap_flag}, 2'b11);
        chk("R10 still zero", count, 0);
    endtask

    initial begin
        t_reset();
        t_stop();
        t_cont();
        t_up();
        t_updn();
        t_enter_above();
        t_rewrite();
        t_zero_period();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule